// File: doc/BRIEF.md
# Circular capture buffer streamer

This block drains a circular audio capture ring that a remote producer fills and copies it into a local circular destination buffer. A pass begins on a periodic tick or on a trigger. The block first fetches the producer's write pointer from the word at the head of the remote region, then works out how many bytes are new since its own read offset. It moves them as a sequence of contiguous memory-read segments, each paired with a destination offset, and pulses a period flag each time a configured period's worth of bytes has been handed over.

Either ring can wrap in the middle of a chunk, so one chunk turns into as many as four segments. A chunk larger than the destination can hold keeps only its newest part. A trigger makes the next pass rewind a fixed pre-roll distance behind the write pointer, so recent history is delivered as well. The data itself is moved elsewhere; this block only sequences addresses, lengths and offsets.

Top module: `capture_ring_streamer`

## Requirements
- R1: Every pass begins with one 4-byte read request at the region base (`BASE_ADDR`). The word returned, minus 4, is the zero-based write offset; the usable ring holds `RING_BYTES` - 4 bytes.
- R2: A zero-based write offset that is not below the usable ring size (including a raw word below 4) ends the pass with a one-cycle `err_o` pulse, issues no data request, and leaves the read offset, destination offset and a pending trigger unchanged.
- R3: A trigger sets the read offset to `PREROLL_BYTES` behind the write offset at the next pass with a valid pointer, wrapping to usable size minus (pre-roll minus write offset) when the write offset is below the pre-roll; a trigger that arrives while a pass is running is held for the next pass.
- R4: The bytes to move are write minus read when read is at or below write, and otherwise usable size plus write minus read; after an error-free pass the read offset equals the write offset, and zero new bytes give no request.
- R5: Data requests address `BASE_ADDR` + 4 + ring offset; a chunk running past the end of the usable ring is split there and resumes at ring offset 0.
- R6: Each chunk is the lesser of the bytes still to move and the period size minus the bytes already counted in the current period; when the count reaches the period size, `period_o` pulses for one cycle and the count restarts at 0.
- R7: When a contiguous source block exceeds destination size minus one frame, only its last (destination size minus one frame) bytes are requested.
- R8: A block that crosses the destination end is requested as a tail part at the current destination offset followed by a part at destination offset 0; a destination offset landing exactly on the destination size becomes 0.
- R9: A destination smaller than two frames makes a chunk end the pass with an `err_o` pulse and no data request, leaving the read offset unchanged.
- R10: `busy_o` is high from the cycle after a start until the pass ends; a tick or trigger while busy starts no extra pass.
- R11: After reset the block is idle with read offset 0, destination offset 0, and no request, period or error output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Periodic pass start |
| trigger_i | input | 1 | Pass start with pre-roll rewind |
| cfg_dst_bytes_i | input | CNT_W | Destination buffer size in bytes |
| cfg_period_bytes_i | input | CNT_W | Period size in bytes |
| cfg_frame_bytes_i | input | CNT_W | Frame size in bytes |
| rd_req_o | output | 1 | Read request, held until done |
| rd_addr_o | output | AW | Remote read address |
| rd_len_o | output | CNT_W | Read length in bytes |
| rd_done_i | input | 1 | Request completed |
| rd_data_i | input | AW | Pointer word returned with done |
| dst_wr_o | output | 1 | Destination write of the current segment |
| dst_wr_off_o | output | CNT_W | Destination offset of the current segment |
| busy_o | output | 1 | Pass in progress |
| period_o | output | 1 | One period delivered |
| err_o | output | 1 | Pass aborted |
| rd_off_o | output | CNT_W | Current ring read offset |
| dst_off_o | output | CNT_W | Current destination offset |

## Verification
Two start causes can land on the same clock: a tick and a trigger pulsed together must give a single pass that applies the rewind. A trigger can also arrive in the middle of a running pass. The bench raises both inputs in one cycle, and separately pulses both while a long pass is running. It then checks that only one pass ran, that the rewind is seen only on the following pass, and that every request matches the model's queue in order.

// File: rtl/csb_pkg.sv
package csb_pkg;
  localparam int CNT_W = 24;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef enum logic [2:0] {S_IDLE, S_PTR, S_CHUNK, S_BLK, S_SEG1, S_SEG2, S_NXT} st_t;

  function automatic cnt_t f_min(cnt_t a, cnt_t b);
    return (a < b) ? a : b;
  endfunction

  // distance behind the write offset, folded into the ring
  function automatic cnt_t f_rewind(cnt_t wr, cnt_t ring, cnt_t pre);
    return (wr < pre) ? ring - (pre - wr) : wr - pre;
  endfunction

  function automatic cnt_t f_fill(cnt_t rd, cnt_t wr, cnt_t ring);
    return (rd <= wr) ? wr - rd : ring + wr - rd;
  endfunction

  function automatic cnt_t f_wrap(cnt_t x, cnt_t ring);
    return (x >= ring) ? x - ring : x;
  endfunction
endpackage

// File: rtl/csb_ring_calc.sv
module csb_ring_calc
  import csb_pkg::*;
#(
  parameter int AW       = 32,
  parameter int RING_USE = 131068,
  parameter int PRE      = 65536
) (
  input  logic [AW-1:0] ptr_word,
  input  cnt_t          rd_off,
  input  logic          rewind,
  output cnt_t          wr_off,
  output logic          ptr_ok,
  output cnt_t          start_rd,
  output cnt_t          fill
);
  logic [AW-1:0] zb;

  always_comb begin
    zb       = ptr_word - AW'(4);
    ptr_ok   = zb < AW'(RING_USE);
    wr_off   = zb[CNT_W-1:0];
    start_rd = rewind ? f_rewind(wr_off, cnt_t'(RING_USE), cnt_t'(PRE)) : rd_off;
    fill     = f_fill(start_rd, wr_off, cnt_t'(RING_USE));
  end
endmodule

// File: rtl/csb_dst_split.sv
module csb_dst_split
  import csb_pkg::*;
(
  input  cnt_t beg,
  input  cnt_t fin,
  input  cnt_t dst_size,
  input  cnt_t frame,
  input  cnt_t dst_off,
  output logic bad,
  output cnt_t src,
  output cnt_t len1,
  output cnt_t len2
);
  cnt_t cap, span, len;
  logic trunc, wrap;

  always_comb begin
    cap   = dst_size - frame;
    span  = fin - beg;
    bad   = (dst_size < (frame << 1)) || (beg > fin);
    trunc = span > cap;
    len   = trunc ? cap : span;
    src   = trunc ? fin - cap : beg;
    wrap  = (dst_off + len) > dst_size;
    len1  = wrap ? dst_size - dst_off : len;
    len2  = wrap ? len - len1 : '0;
  end
endmodule

// File: rtl/capture_ring_streamer.sv
module capture_ring_streamer
  import csb_pkg::*;
#(
  parameter int          AW            = 32,
  parameter int          RING_BYTES    = 131072,
  parameter int          PREROLL_BYTES = 65536,
  parameter logic [31:0] BASE_ADDR     = 32'h6003_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             trigger_i,
  input  logic [CNT_W-1:0] cfg_dst_bytes_i,
  input  logic [CNT_W-1:0] cfg_period_bytes_i,
  input  logic [CNT_W-1:0] cfg_frame_bytes_i,
  output logic             rd_req_o,
  output logic [AW-1:0]    rd_addr_o,
  output logic [CNT_W-1:0] rd_len_o,
  input  logic             rd_done_i,
  input  logic [AW-1:0]    rd_data_i,
  output logic             dst_wr_o,
  output logic [CNT_W-1:0] dst_wr_off_o,
  output logic             busy_o,
  output logic             period_o,
  output logic             err_o,
  output logic [CNT_W-1:0] rd_off_o,
  output logic [CNT_W-1:0] dst_off_o
);
  localparam int   USE   = RING_BYTES - 4;
  localparam cnt_t USE_C = cnt_t'(USE);
  localparam logic [AW-1:0] DATA_BASE = AW'(BASE_ADDR) + AW'(4);

  st_t  state;
  cnt_t rd_off, dst_off, acc, remain, chunk, tgt;
  cnt_t blk_beg, blk_end, seg_src, seg_len1, seg_len2;
  logic blk_sel, trig_pend, period_q, err_q;

  // named internal events for the assertions
  cnt_t wr_off, start_rd, fill, c_chunk;
  logic ptr_ok, sp_bad;
  cnt_t sp_src, sp_len1, sp_len2;

  csb_ring_calc #(.AW(AW), .RING_USE(USE), .PRE(PREROLL_BYTES)) i_ring (
    .ptr_word(rd_data_i), .rd_off(rd_off), .rewind(trig_pend),
    .wr_off(wr_off), .ptr_ok(ptr_ok), .start_rd(start_rd), .fill(fill)
  );

  csb_dst_split i_split (
    .beg(blk_beg), .fin(blk_end), .dst_size(cfg_dst_bytes_i),
    .frame(cfg_frame_bytes_i), .dst_off(dst_off),
    .bad(sp_bad), .src(sp_src), .len1(sp_len1), .len2(sp_len2)
  );

  assign c_chunk = f_min(remain, cfg_period_bytes_i - acc);

  always_comb begin
    rd_req_o     = (state == S_PTR) || (state == S_SEG1) || (state == S_SEG2);
    rd_addr_o    = AW'(BASE_ADDR);
    rd_len_o     = cnt_t'(4);
    dst_wr_off_o = dst_off;
    if (state == S_SEG1) begin
      rd_addr_o = DATA_BASE + AW'(seg_src);
      rd_len_o  = seg_len1;
    end else if (state == S_SEG2) begin
      rd_addr_o    = DATA_BASE + AW'(seg_src + seg_len1);
      rd_len_o     = seg_len2;
      dst_wr_off_o = '0;
    end
    dst_wr_o = rd_done_i && ((state == S_SEG1) || (state == S_SEG2));
  end

  assign busy_o    = state != S_IDLE;
  assign period_o  = period_q;
  assign err_o     = err_q;
  assign rd_off_o  = rd_off;
  assign dst_off_o = dst_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;   rd_off <= '0;   dst_off <= '0;  acc <= '0;
      remain <= '0;      chunk <= '0;    tgt <= '0;      blk_beg <= '0;
      blk_end <= '0;     seg_src <= '0;  seg_len1 <= '0; seg_len2 <= '0;
      blk_sel <= 1'b0;   trig_pend <= 1'b0;
      period_q <= 1'b0;  err_q <= 1'b0;
    end else begin
      period_q <= 1'b0;
      err_q    <= 1'b0;
      case (state)
        S_IDLE: if (tick_i || trigger_i) state <= S_PTR;
        S_PTR: if (rd_done_i) begin
          if (!ptr_ok) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end else begin
            rd_off    <= start_rd;
            remain    <= fill;
            trig_pend <= 1'b0;
            state     <= S_CHUNK;
          end
        end
        S_CHUNK: begin
          if (remain == '0) state <= S_IDLE;
          else begin
            chunk   <= c_chunk;
            tgt     <= rd_off + c_chunk;
            blk_beg <= rd_off;
            blk_end <= f_min(rd_off + c_chunk, USE_C);
            blk_sel <= 1'b0;
            state   <= S_BLK;
          end
        end
        S_BLK: begin
          if (sp_bad) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end else if (blk_beg == blk_end) state <= S_NXT;
          else begin
            seg_src  <= sp_src;
            seg_len1 <= sp_len1;
            seg_len2 <= sp_len2;
            state    <= S_SEG1;
          end
        end
        S_SEG1: if (rd_done_i) begin
          dst_off <= (dst_off + seg_len1 == cfg_dst_bytes_i) ? '0 : dst_off + seg_len1;
          state   <= (seg_len2 != '0) ? S_SEG2 : S_NXT;
        end
        S_SEG2: if (rd_done_i) begin
          dst_off <= seg_len2;
          state   <= S_NXT;
        end
        S_NXT: begin
          if (!blk_sel && tgt >= USE_C) begin
            blk_beg <= '0;
            blk_end <= tgt - USE_C;
            blk_sel <= 1'b1;
            state   <= S_BLK;
          end else begin
            rd_off <= f_wrap(tgt, USE_C);
            remain <= remain - chunk;
            if (acc + chunk >= cfg_period_bytes_i) begin
              acc      <= '0;
              period_q <= 1'b1;
            end else acc <= acc + chunk;
            state <= S_CHUNK;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (trigger_i) trig_pend <= 1'b1;
    end
  end

  assert_src_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SEG1) |-> (seg_src + seg_len1 + seg_len2 <= USE_C));
  assert_dst_fits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SEG1) |-> (dst_off + seg_len1 <= cfg_dst_bytes_i));
  assert_trunc_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SEG1) |-> (seg_len1 + seg_len2 <= cfg_dst_bytes_i - cfg_frame_bytes_i));
  assert_rd_off_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_off < USE_C);
  assert_period_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    period_o |=> !period_o);
  assert_start_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(tick_i || trigger_i));
  assert_err_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o);
endmodule

// File: tb/test_capture_ring_streamer.sv
`timescale 1ns/1ps
module test_capture_ring_streamer;
  localparam int RING = 256;
  localparam int USEB = RING - 4;
  localparam int PRE  = 64;
  localparam int BASE = 32'h1000;

  logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0, trigger_i = 1'b0;
  logic [23:0] cfg_dst = 24'd64, cfg_per = 24'd16, cfg_frm = 24'd2;
  logic rd_req_o, rd_done_i = 1'b0, dst_wr_o, busy_o, period_o, err_o;
  logic [31:0] rd_addr_o, rd_data_i = '0;
  logic [23:0] rd_len_o, dst_wr_off_o, rd_off_o, dst_off_o;

  always #2.5 clk = ~clk;

  capture_ring_streamer #(.AW(32), .RING_BYTES(RING), .PREROLL_BYTES(PRE),
                          .BASE_ADDR(BASE)) i_capture_ring_streamer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .trigger_i(trigger_i),
    .cfg_dst_bytes_i(cfg_dst), .cfg_period_bytes_i(cfg_per), .cfg_frame_bytes_i(cfg_frm),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_len_o(rd_len_o),
    .rd_done_i(rd_done_i), .rd_data_i(rd_data_i), .dst_wr_o(dst_wr_o),
    .dst_wr_off_o(dst_wr_off_o), .busy_o(busy_o), .period_o(period_o),
    .err_o(err_o), .rd_off_o(rd_off_o), .dst_off_o(dst_off_o));

  int n_chk = 0, n_bad = 0, pulse_cnt = 0;
  int q_addr[$], q_len[$], q_doff[$];
  // reference state
  int m_rd, m_doff, m_acc, e_pulses;
  bit m_trig, e_err;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int a, input int l, input int d);
    q_addr.push_back(a); q_len.push_back(l); q_doff.push_back(d);
  endtask

  // one contiguous source block into the destination ring
  task automatic emit_block(input int b, input int e);
    int len, cap, part;
    len = e - b;
    if (len == 0) return;
    cap = int'(cfg_dst) - int'(cfg_frm);
    if (len > cap) begin b = e - cap; len = cap; end          // R7
    if (m_doff + len > int'(cfg_dst)) begin                     // R8
      part = int'(cfg_dst) - m_doff;
      push(BASE + 4 + b, part, m_doff);
      push(BASE + 4 + b + part, len - part, 0);
      m_doff = len - part;
    end else begin
      push(BASE + 4 + b, len, m_doff);
      m_doff = m_doff + len;
      if (m_doff == int'(cfg_dst)) m_doff = 0;
    end
  endtask

  task automatic predict(input int raw);
    int w, n, c, stop;
    e_err = 0; e_pulses = 0;
    push(BASE, 4, -1);                                          // R1
    w = raw - 4;
    if (w < 0 || w >= USEB) begin e_err = 1; return; end        // R2
    if (m_trig) begin                                           // R3
      m_rd = (w >= PRE) ? w - PRE : USEB - PRE + w;
      m_trig = 0;
    end
    n = (m_rd <= w) ? w - m_rd : USEB - m_rd + w;               // R4
    while (n > 0) begin
      c = n < (int'(cfg_per) - m_acc) ? n : int'(cfg_per) - m_acc;  // R6
      if (int'(cfg_dst) < 2 * int'(cfg_frm)) begin e_err = 1; return; end  // R9
      stop = m_rd + c;
      emit_block(m_rd, stop < USEB ? stop : USEB);              // R5
      if (stop >= USEB) begin emit_block(0, stop - USEB); stop = stop - USEB; end
      m_rd = stop;
      m_acc = m_acc + c;
      if (m_acc >= int'(cfg_per)) begin e_pulses++; m_acc = 0; end
      n = n - c;
    end
  endtask

  // remote memory: serve each request, compare with the queue
  initial begin
    forever begin
      @(negedge clk);
      if (rd_done_i) rd_done_i = 1'b0;
      else if (rd_req_o) begin
        if (q_addr.size() == 0) check(0, "R10 unexpected request", int'(rd_addr_o), -1);
        else begin
          check(int'(rd_addr_o) == q_addr[0], "R5 req address", int'(rd_addr_o), q_addr[0]);
          check(int'(rd_len_o) == q_len[0], "R6 req length", int'(rd_len_o), q_len[0]);
          if (q_doff[0] >= 0)
            check(int'(dst_wr_off_o) == q_doff[0], "R8 dst offset", int'(dst_wr_off_o), q_doff[0]);
          void'(q_addr.pop_front()); void'(q_len.pop_front()); void'(q_doff.pop_front());
        end
        rd_done_i = 1'b1;
      end
    end
  end

  always @(negedge clk) if (period_o) pulse_cnt++;

  task automatic finish_pass(input int p0, input string tag);
    while (busy_o) @(negedge clk);
    check(err_o == e_err, {tag, " error flag"}, int'(err_o), int'(e_err));
    check(pulse_cnt - p0 == e_pulses, {tag, " R6 period pulses"}, pulse_cnt - p0, e_pulses);
    check(int'(rd_off_o) == m_rd, {tag, " R4 read offset"}, int'(rd_off_o), m_rd);
    check(int'(dst_off_o) == m_doff, {tag, " R8 dst offset"}, int'(dst_off_o), m_doff);
    check(q_addr.size() == 0, {tag, " requests left"}, q_addr.size(), 0);
    repeat (4) @(negedge clk);
    check(!busy_o, {tag, " R10 idle after pass"}, int'(busy_o), 0);
  endtask

  task automatic pass(input int raw, input bit tk, input bit tg, input string tag);
    int p0;
    if (tg) m_trig = 1;
    rd_data_i = 32'(raw);
    predict(raw);
    p0 = pulse_cnt;
    @(negedge clk); tick_i = tk; trigger_i = tg;
    @(negedge clk); tick_i = 0; trigger_i = 0;
    finish_pass(p0, tag);
  endtask

  task automatic do_reset(input int dst, input int per, input int frm);
    @(negedge clk); rst_n = 0;
    cfg_dst = 24'(dst); cfg_per = 24'(per); cfg_frm = 24'(frm);
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_rd = 0; m_doff = 0; m_acc = 0; m_trig = 0;
    @(negedge clk);
    check(!busy_o && !rd_req_o && !period_o && !err_o, "R11 idle outputs", int'(busy_o), 0);
    check(rd_off_o == 0 && dst_off_o == 0, "R11 offsets", int'(rd_off_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int p0;
    do_reset(64, 16, 2);
    pass(4 + 40, 1, 0, "R1 first drain");
    pass(4 + 100, 1, 0, "R8 dst wrap and exact end");
    pass(4 + 30, 1, 0, "R5 source wrap");
    pass(4 + 20, 0, 1, "R3 rewind below preroll");
    pass(4 + 150, 1, 1, "R3 tick and trigger together");
    pass(4 + 150, 1, 0, "R4 no new bytes");
    pass(4 + 252, 0, 1, "R2 pointer at ring size");
    pass(2, 1, 0, "R2 pointer below header");
    pass(4 + 200, 1, 0, "R3 pending kept after error");
    // trigger and tick while a long pass runs
    rd_data_i = 32'(4 + 120);
    predict(4 + 120);
    p0 = pulse_cnt;
    @(negedge clk); tick_i = 1;
    @(negedge clk); tick_i = 0;
    repeat (6) @(negedge clk);
    check(busy_o, "R10 still busy", int'(busy_o), 1);
    trigger_i = 1; tick_i = 1;
    @(negedge clk); trigger_i = 0; tick_i = 0;
    m_trig = 1;
    finish_pass(p0, "R10 starts while busy");
    pass(4 + 30, 1, 0, "R3 held trigger applied");
    do_reset(16, 64, 2);
    pass(4 + 100, 1, 0, "R7 truncation");
    do_reset(2, 16, 2);
    pass(4, 1, 0, "R4 zero fill");
    pass(4 + 10, 1, 0, "R9 destination too small");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule